// File: doc/BRIEF.md
# Four-Way Translation Buffer Lookup with Protection Faults

This block sits on the paged address translation path. It holds two separate sets of entries, one for instruction fetches and one for data accesses. Each set is four ways deep with sixteen rows per way. A request carries a virtual address, an access kind, a user/kernel flag, a debug flag, the current 8-bit process ID and four check-enable bits. The block looks the page up in all four ways of one row. It then applies the enabled permission checks in a fixed order. It returns the physical page number, the read/write/execute permissions, a miss flag and an exception vector number.

When a lookup faults and is not a debug lookup, the block writes a select register and a cause register that refill software reads. It also advances a 16-bit LFSR whose two low bits propose a victim way for the next refill. Software loads entries through a single write port. Page-table walks and exception entry happen outside the block.

A two-state controller sequences each request. In `ST_IDLE` the request is accepted: `req_ready` is high, and the transition *accept* to `ST_LOOKUP` is taken when `req_valid` is high. `ST_LOOKUP` always takes the transition *complete* back to `ST_IDLE`. On that edge it registers the response and, on a non-debug fault, the select and cause registers. The response therefore appears two clock edges after the accepting edge and lasts one cycle.

Top module: `tlb_lookup`

## Requirements
- R1: After reset, `rsp_valid` is 0, `req_ready` is 1, `fault_sel` is 0, `fault_cause` is 0 and every entry word is 0.
- R2: A request accepted at an edge (`req_valid` high while `req_ready` is high) produces `rsp_valid` high for exactly one cycle, starting at the second edge after acceptance. No new request is accepted in the cycle in between.
- R3: The page number is `req_vaddr[31:13]` and the row is its low four bits. An entry hits when its high word bits [31:13] equal the page number and either its low word bit 4 (global) is set or its high word bits [7:0] equal `cur_pid`. When several ways hit, the lowest-numbered way is used.
- R4: For a hit entry, the checks apply in this priority, and the first one that fails sets `rsp_miss` with the given vector offset:
  - kernel: `chk_en[2]` set, low word bit 2 set and `req_user` high gives offset 2;
  - write: write access, `chk_en[3]` set and low word bit 1 clear gives offset 3;
  - execute: execute access, `chk_en[1]` set and low word bit 0 clear gives offset 3;
  - valid: `chk_en[0]` set and low word bit 3 clear gives offset 1.

  A lookup with no hit is a refill miss with offset 0. `rsp_vec` is the base plus the offset.
- R5: `req_acc` encodes 0 = read, 1 = write, 2 = execute, and 3 is treated as a read. Execute lookups use the instruction entries (`wr_side` = 0) with vector base 4. All other lookups use the data entries (`wr_side` = 1) with vector base 8.
- R6: On a lookup without a fault, `rsp_rd` is 1, `rsp_wr` equals low word bit 1, and `rsp_ex` is 1 only for an instruction-side lookup where `chk_en[1]` is clear or low word bit 0 is set. On any fault all three are 0.
- R7: The victim LFSR starts at 0xCCCC. On each non-debug fault it shifts right by one, and bit 15 takes the parity of (state AND 0x8805). A refill miss proposes way = LFSR[1:0], read before the shift.
- R8: On a non-debug fault, `fault_sel` becomes {way[1:0], row[3:0]}. The way is the hit way for a protection fault and the victim way for a refill miss.
- R9: On a non-debug fault, `fault_cause` becomes {page number in [31:13], 0 in [12:10], cause code 0/1/2 in [9:8], `cur_pid` in [7:0]}.
- R10: A lookup with `req_debug` high returns its normal response but leaves `fault_sel`, `fault_cause` and the LFSR unchanged.
- R11: When `wr_en` is high at an edge, `wr_hi` and `wr_lo` are stored at (`wr_side`, `wr_way`, `wr_row`), and the next lookup sees the new entry.
- R12: `rsp_pfn` carries the hit entry's low word bits [31:13], including on a protection fault. It is 0 on a refill miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Lookup request |
| req_ready | output | 1 | Controller is idle and accepts a request |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| req_user | input | 1 | User-mode access |
| req_debug | input | 1 | Debug lookup, no side effects |
| cur_pid | input | 8 | Current process ID |
| chk_en | input | 4 | Check enables: [3] write, [2] kernel, [1] execute, [0] valid |
| wr_en | input | 1 | Entry write strobe |
| wr_side | input | 1 | 0 instruction entries, 1 data entries |
| wr_way | input | 2 | Way to write |
| wr_row | input | 4 | Row to write |
| wr_hi | input | 32 | Entry high word (tag, PID) |
| wr_lo | input | 32 | Entry low word (frame, flags) |
| rsp_valid | output | 1 | Response strobe |
| rsp_miss | output | 1 | Refill miss or protection fault |
| rsp_vec | output | 4 | Exception vector number |
| rsp_pfn | output | 19 | Physical page number |
| rsp_rd | output | 1 | Read permitted |
| rsp_wr | output | 1 | Write permitted |
| rsp_ex | output | 1 | Execute permitted |
| fault_sel | output | 6 | Fault select register {way, row} |
| fault_cause | output | 32 | Fault cause register |

## Verification
Several properties are checked on every cycle:
- the response timing and its single-cycle pulse;
- the absence of any permission on a fault and the read grant on every clean hit;
- execute permission appearing only with the instruction vector base;
- the select and cause registers holding across debug lookups;
- the row and page fields those registers capture;
- the LFSR never reaching zero and holding between faults.

Other behaviour needs the bench's scenarios: which of several hitting ways wins, the order among competing protection checks, the exact pseudo-random victim sequence, and the visibility of refilled entries. These depend on entry contents and on history. A reference model in the bench compares them against random and directed lookups.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W       = 32;
    localparam int PAGE_SHIFT = 13;
    localparam int VPN_W      = VA_W - PAGE_SHIFT;
    localparam int PID_W      = 8;
    localparam int CHK_W      = 4;

    // low word flag positions
    localparam int LO_GLB = 4;
    localparam int LO_VAL = 3;
    localparam int LO_KRN = 2;
    localparam int LO_WR  = 1;
    localparam int LO_EX  = 0;

    // check enable positions
    localparam int CK_WR  = 3;
    localparam int CK_KRN = 2;
    localparam int CK_EX  = 1;
    localparam int CK_VAL = 0;

    localparam logic [1:0] ACC_READ  = 2'd0;
    localparam logic [1:0] ACC_WRITE = 2'd1;
    localparam logic [1:0] ACC_EXEC  = 2'd2;

    localparam logic [1:0] OFF_REFILL  = 2'd0;
    localparam logic [1:0] OFF_INVALID = 2'd1;
    localparam logic [1:0] OFF_KERNEL  = 2'd2;
    localparam logic [1:0] OFF_PERM    = 2'd3;

    localparam logic [3:0] VEC_INSN = 4'd4;
    localparam logic [3:0] VEC_DATA = 4'd8;

    typedef enum logic {ST_IDLE, ST_LOOKUP} state_e;

    typedef struct packed {
        logic [VPN_W-1:0] vpn;
        logic [1:0]       acc;
        logic             user;
        logic             dbg;
        logic [PID_W-1:0] pid;
        logic [CHK_W-1:0] chk;
    } req_t;
endpackage

// File: rtl/tlb_store.sv
module tlb_store #(
    parameter int WAYS = 4,
    parameter int ROWS = 16,
    localparam int WAY_W = $clog2(WAYS),
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic                       wr_side,
    input  logic [WAY_W-1:0]           wr_way,
    input  logic [ROW_W-1:0]           wr_row,
    input  logic [31:0]                wr_hi,
    input  logic [31:0]                wr_lo,
    input  logic                       rd_side,
    input  logic [ROW_W-1:0]           rd_row,
    output logic [WAYS-1:0][31:0]      rd_hi,
    output logic [WAYS-1:0][31:0]      rd_lo
);
    logic [31:0] side_hi [2][WAYS];
    logic [31:0] side_lo [2][WAYS];

    for (genvar s = 0; s < 2; s++) begin : g_side
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            logic [31:0] hi_mem [ROWS];
            logic [31:0] lo_mem [ROWS];
            logic        hit_wr;
            assign hit_wr = wr_en && (wr_side == 1'(s)) && (wr_way == WAY_W'(w));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int r = 0; r < ROWS; r++) begin
                        hi_mem[r] <= '0;
                        lo_mem[r] <= '0;
                    end
                end else if (hit_wr) begin
                    hi_mem[wr_row] <= wr_hi;
                    lo_mem[wr_row] <= wr_lo;
                end
            end

            assign side_hi[s][w] = hi_mem[rd_row];
            assign side_lo[s][w] = lo_mem[rd_row];
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign rd_hi[w] = side_hi[rd_side][w];
        assign rd_lo[w] = side_lo[rd_side][w];
    end
endmodule

// File: rtl/tlb_check.sv
module tlb_check
    import tlb_pkg::*;
#(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][31:0] ent_hi,
    input  logic [WAYS-1:0][31:0] ent_lo,
    input  logic [VPN_W-1:0]      vpn,
    input  logic [PID_W-1:0]      pid,
    input  logic [1:0]            acc,
    input  logic                  user,
    input  logic                  insn_side,
    input  logic [CHK_W-1:0]      chk,
    output logic                  hit,
    output logic [WAY_W-1:0]      hit_way,
    output logic                  prot_flt,
    output logic [1:0]            vec_off,
    output logic [VPN_W-1:0]      pfn,
    output logic [2:0]            perm      // {rd, wr, ex}
);
    logic [WAYS-1:0] way_hit;
    logic [31:0]     sel_lo;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        logic unused_gap;
        assign unused_gap = ^{ent_hi[w][PAGE_SHIFT-1:PID_W], ent_lo[w][PAGE_SHIFT-1:LO_GLB+1]};
        assign way_hit[w] = (ent_hi[w][VA_W-1:PAGE_SHIFT] == vpn) &&
                            (ent_lo[w][LO_GLB] || (ent_hi[w][PID_W-1:0] == pid));
    end

    // lowest-numbered way wins: scan downward so the last assignment is the lowest
    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (way_hit[w]) hit_way = WAY_W'(w);
        end
    end

    assign hit    = |way_hit;
    assign sel_lo = ent_lo[hit_way];
    assign pfn    = hit ? sel_lo[VA_W-1:PAGE_SHIFT] : '0;

    always_comb begin
        prot_flt = 1'b0;
        vec_off  = OFF_REFILL;
        if (hit) begin
            if (chk[CK_KRN] && sel_lo[LO_KRN] && user) begin
                prot_flt = 1'b1;
                vec_off  = OFF_KERNEL;
            end else if (acc == ACC_WRITE && chk[CK_WR] && !sel_lo[LO_WR]) begin
                prot_flt = 1'b1;
                vec_off  = OFF_PERM;
            end else if (acc == ACC_EXEC && chk[CK_EX] && !sel_lo[LO_EX]) begin
                prot_flt = 1'b1;
                vec_off  = OFF_PERM;
            end else if (chk[CK_VAL] && !sel_lo[LO_VAL]) begin
                prot_flt = 1'b1;
                vec_off  = OFF_INVALID;
            end
        end
    end

    assign perm = {1'b1, sel_lo[LO_WR], insn_side && (!chk[CK_EX] || sel_lo[LO_EX])};
endmodule

// File: rtl/tlb_victim_lfsr.sv
module tlb_victim_lfsr #(
    parameter int          W    = 16,
    parameter logic [W-1:0] SEED = 16'hCCCC,
    parameter logic [W-1:0] TAPS = 16'h8805
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] state
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    state <= SEED;
        else if (step) state <= {^(state & TAPS), state[W-1:1]};
    end

    // R7: a nonzero seed with tap 0 set never collapses to zero
    p_lfsr_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n) state != '0);
    // R7: the state only moves on a fault step
    p_lfsr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n) !step |=> $stable(state));
endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
    import tlb_pkg::*;
#(
    parameter int           WAYS      = 4,
    parameter int           ROWS      = 16,
    parameter logic [15:0]  LFSR_SEED = 16'hCCCC,
    parameter logic [15:0]  LFSR_TAPS = 16'h8805,
    localparam int WAY_W = $clog2(WAYS),
    localparam int ROW_W = $clog2(ROWS),
    localparam int SEL_W = WAY_W + ROW_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [31:0]      req_vaddr,
    input  logic [1:0]       req_acc,
    input  logic             req_user,
    input  logic             req_debug,
    input  logic [7:0]       cur_pid,
    input  logic [3:0]       chk_en,
    input  logic             wr_en,
    input  logic             wr_side,
    input  logic [WAY_W-1:0] wr_way,
    input  logic [ROW_W-1:0] wr_row,
    input  logic [31:0]      wr_hi,
    input  logic [31:0]      wr_lo,
    output logic             rsp_valid,
    output logic             rsp_miss,
    output logic [3:0]       rsp_vec,
    output logic [18:0]      rsp_pfn,
    output logic             rsp_rd,
    output logic             rsp_wr,
    output logic             rsp_ex,
    output logic [SEL_W-1:0] fault_sel,
    output logic [31:0]      fault_cause
);
    state_e state_q, state_d;
    req_t   req_q;

    logic                 insn_side, hit, prot_flt, miss_c, fault_upd;
    logic [WAY_W-1:0]     hit_way, use_way;
    logic [1:0]           vec_off, cause_code;
    logic [VPN_W-1:0]     pfn_c;
    logic [2:0]           perm_c;
    logic [3:0]           vec_c;
    logic [ROW_W-1:0]     row_q;
    logic [WAYS-1:0][31:0] ent_hi, ent_lo;
    logic [15:0]          lfsr_q;

    logic unused_bits;
    assign unused_bits = ^{req_vaddr[PAGE_SHIFT-1:0], lfsr_q[15:WAY_W]};

    assign req_ready = (state_q == ST_IDLE);

    // next-state: accept (IDLE->LOOKUP), complete (LOOKUP->IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_LOOKUP;
            ST_LOOKUP: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= '0;
        end else if (req_ready && req_valid) begin
            req_q <= '{vpn:  req_vaddr[VA_W-1:PAGE_SHIFT], acc: req_acc, user: req_user,
                       dbg:  req_debug, pid: cur_pid, chk: chk_en};
        end
    end

    assign row_q      = req_q.vpn[ROW_W-1:0];
    assign insn_side  = (req_q.acc == ACC_EXEC);
    assign cause_code = (req_q.acc == 2'd3) ? ACC_READ : req_q.acc;

    tlb_store #(.WAYS(WAYS), .ROWS(ROWS)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_side(wr_side), .wr_way(wr_way),
        .wr_row(wr_row), .wr_hi(wr_hi), .wr_lo(wr_lo), .rd_side(!insn_side),
        .rd_row(row_q), .rd_hi(ent_hi), .rd_lo(ent_lo)
    );

    tlb_check #(.WAYS(WAYS)) u_check (
        .ent_hi(ent_hi), .ent_lo(ent_lo), .vpn(req_q.vpn), .pid(req_q.pid),
        .acc(req_q.acc), .user(req_q.user), .insn_side(insn_side), .chk(req_q.chk),
        .hit(hit), .hit_way(hit_way), .prot_flt(prot_flt), .vec_off(vec_off),
        .pfn(pfn_c), .perm(perm_c)
    );

    assign miss_c    = !hit || prot_flt;
    assign vec_c     = (insn_side ? VEC_INSN : VEC_DATA) + {2'b00, vec_off};
    assign use_way   = hit ? hit_way : lfsr_q[WAY_W-1:0];
    assign fault_upd = (state_q == ST_LOOKUP) && miss_c && !req_q.dbg;

    tlb_victim_lfsr #(.W(16), .SEED(LFSR_SEED), .TAPS(LFSR_TAPS)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .step(fault_upd), .state(lfsr_q)
    );

    // output process: response and fault registers, written on completion
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_miss    <= 1'b0;
            rsp_vec     <= '0;
            rsp_pfn     <= '0;
            {rsp_rd, rsp_wr, rsp_ex} <= '0;
            fault_sel   <= '0;
            fault_cause <= '0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: ;
                ST_LOOKUP: begin
                    rsp_valid <= 1'b1;
                    rsp_miss  <= miss_c;
                    rsp_vec   <= vec_c;
                    rsp_pfn   <= pfn_c;
                    {rsp_rd, rsp_wr, rsp_ex} <= miss_c ? 3'b000 : perm_c;
                    if (fault_upd) begin
                        fault_sel   <= {use_way, row_q};
                        fault_cause <= {req_q.vpn, 3'b000, cause_code, req_q.pid};
                    end
                end
            endcase
        end
    end

    // R2: response two edges after acceptance, one cycle long
    p_resp_timing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && req_ready, 2));
    p_resp_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R6: no permission on a fault, read on every clean hit, execute only with the instruction base
    p_fault_noperm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_miss) |-> !(rsp_rd || rsp_wr || rsp_ex));
    p_hit_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_miss) |-> rsp_rd);
    p_exec_insn_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ex) |-> rsp_vec == VEC_INSN);
    // R10: debug lookups leave the fault registers alone
    p_debug_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP && req_q.dbg) |=> ($stable(fault_sel) && $stable(fault_cause)));
    // R8, R9: captured row and page on a recorded fault
    p_sel_row_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_miss && !req_q.dbg) |-> fault_sel[ROW_W-1:0] == req_q.vpn[ROW_W-1:0]);
    p_cause_vpn_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_miss && !req_q.dbg) |-> fault_cause[31:PAGE_SHIFT] == req_q.vpn);
endmodule

// File: tb/tlb_lookup_tb.sv
module tlb_lookup_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, req_user = 0, req_debug = 0;
    logic [31:0] req_vaddr = '0;
    logic [1:0] req_acc = '0;
    logic [7:0] cur_pid = '0;
    logic [3:0] chk_en = '0;
    logic wr_en = 0, wr_side = 0;
    logic [1:0] wr_way = '0;
    logic [3:0] wr_row = '0;
    logic [31:0] wr_hi = '0, wr_lo = '0;
    logic req_ready, rsp_valid, rsp_miss, rsp_rd, rsp_wr, rsp_ex;
    logic [3:0] rsp_vec;
    logic [18:0] rsp_pfn;
    logic [5:0] fault_sel;
    logic [31:0] fault_cause;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [31:0] m_hi [2][4][16];
    logic [31:0] m_lo [2][4][16];
    logic [15:0] m_lfsr;
    logic [5:0]  m_sel;
    logic [31:0] m_cause;

    always #10 clk = ~clk;   // 50 MHz

    tlb_lookup u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_acc(req_acc), .req_user(req_user), .req_debug(req_debug),
        .cur_pid(cur_pid), .chk_en(chk_en), .wr_en(wr_en), .wr_side(wr_side), .wr_way(wr_way),
        .wr_row(wr_row), .wr_hi(wr_hi), .wr_lo(wr_lo), .rsp_valid(rsp_valid), .rsp_miss(rsp_miss),
        .rsp_vec(rsp_vec), .rsp_pfn(rsp_pfn), .rsp_rd(rsp_rd), .rsp_wr(rsp_wr), .rsp_ex(rsp_ex),
        .fault_sel(fault_sel), .fault_cause(fault_cause)
    );

    function automatic logic [15:0] lfsr_next(input logic [15:0] s);
        return {^(s & 16'h8805), s[15:1]};
    endfunction

    function automatic logic [14:0] vhi(input int i);
        case (i % 4)
            0: return 15'h0010;
            1: return 15'h1234;
            2: return 15'h7fff;
            default: return 15'h0abc;
        endcase
    endfunction

    task automatic check(input string what, input logic [63:0] got, input logic [63:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", what, got, exp);
        end
    endtask

    task automatic do_write(input logic side, input logic [1:0] way, input logic [3:0] row,
                            input logic [31:0] hi, input logic [31:0] lo);
        @(negedge clk);
        wr_en = 1; wr_side = side; wr_way = way; wr_row = row; wr_hi = hi; wr_lo = lo;
        @(negedge clk);
        wr_en = 0;
        m_hi[side][way][row] = hi;
        m_lo[side][way][row] = lo;
    endtask

    task automatic do_lookup(input string tag, input logic [31:0] va, input logic [1:0] acc,
                             input logic usr, input logic dbg, input logic [7:0] pid,
                             input logic [3:0] chk);
        logic side; logic [18:0] vpn; logic [3:0] row; int hw;
        logic [31:0] lo; logic [1:0] off; logic flt, miss; logic [3:0] vec;
        logic [18:0] pfn; logic [2:0] perm; logic [1:0] way, code;
        side = (acc == 2'd2) ? 1'b0 : 1'b1;
        vpn = va[31:13]; row = vpn[3:0]; hw = -1; lo = '0;
        for (int w = 0; w < 4; w++)
            if (hw < 0 && m_hi[side][w][row][31:13] == vpn &&
                (m_lo[side][w][row][4] || m_hi[side][w][row][7:0] == pid)) hw = w;
        off = 0; flt = 0; pfn = '0; perm = '0;
        if (hw >= 0) begin
            lo = m_lo[side][hw][row];
            pfn = lo[31:13];
            if (chk[2] && lo[2] && usr) begin flt = 1; off = 2; end
            else if (acc == 2'd1 && chk[3] && !lo[1]) begin flt = 1; off = 3; end
            else if (acc == 2'd2 && chk[1] && !lo[0]) begin flt = 1; off = 3; end
            else if (chk[0] && !lo[3]) begin flt = 1; off = 1; end
        end
        miss = (hw < 0) || flt;
        if (!miss) perm = {1'b1, lo[1], (side == 1'b0) && (!chk[1] || lo[0])};
        vec = ((side == 1'b0) ? 4'd4 : 4'd8) + {2'b00, off};
        code = (acc == 2'd3) ? 2'd0 : acc;
        way = (hw >= 0) ? hw[1:0] : m_lfsr[1:0];
        if (miss && !dbg) begin
            m_lfsr = lfsr_next(m_lfsr);
            m_sel = {way, row};
            m_cause = {vpn, 3'b000, code, pid};
        end
        @(negedge clk);
        check({"R2 ready ", tag}, 64'(req_ready), 64'd1);
        req_valid = 1; req_vaddr = va; req_acc = acc; req_user = usr; req_debug = dbg;
        cur_pid = pid; chk_en = chk;
        @(negedge clk);
        req_valid = 0;
        check({"R2 busy ", tag}, 64'(req_ready), 64'd0);
        @(negedge clk);
        check({"R2 valid ", tag}, 64'(rsp_valid), 64'd1);
        check({"R4 miss/vec ", tag}, 64'({rsp_miss, rsp_vec}), 64'({miss, vec}));
        check({"R12 pfn ", tag}, 64'(rsp_pfn), 64'(pfn));
        check({"R6 perms ", tag}, 64'({rsp_rd, rsp_wr, rsp_ex}), 64'(perm));
        check({"R8 select ", tag}, 64'(fault_sel), 64'(m_sel));
        check({"R9 cause ", tag}, 64'(fault_cause), 64'(m_cause));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240607));
        for (int s = 0; s < 2; s++)
            for (int w = 0; w < 4; w++)
                for (int r = 0; r < 16; r++) begin m_hi[s][w][r] = '0; m_lo[s][w][r] = '0; end
        m_lfsr = 16'hCCCC; m_sel = '0; m_cause = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
        check("R1 req_ready", 64'(req_ready), 64'd1);
        check("R1 fault_sel", 64'(fault_sel), 64'd0);
        check("R1 fault_cause", 64'(fault_cause), 64'd0);

        // R7: first refill miss uses seed low bits (0xCCCC -> way 0)
        do_lookup("R7 first miss", {15'h1234, 4'd7, 13'h0}, 2'd0, 0, 0, 8'h11, 4'h0);
        check("R7 seed way", 64'(fault_sel[5:4]), 64'd0);
        for (int i = 0; i < 6; i++)
            do_lookup("R7 victim sequence", {15'h0abc, 4'(i), 13'h1}, 2'd1, 0, 0, 8'h22, 4'hF);

        // R3: two ways hit, lowest wins
        do_write(1, 2'd3, 4'd5, {15'h0010, 4'd5, 5'd0, 8'h22}, {19'h33333, 8'd0, 5'b10010});
        do_write(1, 2'd1, 4'd5, {15'h0010, 4'd5, 5'd0, 8'h22}, {19'h11111, 8'd0, 5'b01010});
        do_lookup("R3 lowest way", {15'h0010, 4'd5, 13'h44}, 2'd0, 0, 0, 8'h22, 4'h0);
        check("R3 lowest way pfn", 64'(rsp_pfn), 64'h11111);
        // R3: pid mismatch on way1 lets the global way3 hit
        do_lookup("R3 global", {15'h0010, 4'd5, 13'h44}, 2'd0, 0, 0, 8'h55, 4'h0);
        check("R3 global pfn", 64'(rsp_pfn), 64'h33333);

        // R4: kernel fault outranks write fault (kernel, not writable, user write)
        do_write(1, 2'd0, 4'd9, {15'h7fff, 4'd9, 5'd0, 8'h33}, {19'h2468a, 8'd0, 5'b01100});
        do_lookup("R4 kernel first", {15'h7fff, 4'd9, 13'h0}, 2'd1, 1, 0, 8'h33, 4'hF);
        check("R4 kernel vec", 64'(rsp_vec), 64'd10);
        check("R8 prot way", 64'(fault_sel), 64'({2'd0, 4'd9}));
        do_lookup("R4 write next", {15'h7fff, 4'd9, 13'h0}, 2'd1, 0, 0, 8'h33, 4'hF);
        check("R4 write vec", 64'(rsp_vec), 64'd11);

        // R5: data-side entry is not seen by an execute lookup
        do_lookup("R5 side split", {15'h7fff, 4'd9, 13'h0}, 2'd2, 0, 0, 8'h33, 4'h0);
        check("R5 insn refill vec", 64'({rsp_miss, rsp_vec}), 64'({1'b1, 4'd4}));

        // R10: debug miss leaves fault registers
        do_lookup("R10 debug", {15'h4444, 4'd2, 13'h0}, 2'd0, 0, 1, 8'h01, 4'h0);
        check("R10 cause held", 64'(fault_cause[31:13]), 64'({15'h7fff, 4'd9}));

        // R11: refill through write port then hit on instruction side
        do_write(0, 2'd2, 4'd3, {15'h0abc, 4'd3, 5'd0, 8'h00}, {19'h5a5a5, 8'd0, 5'b11001});
        do_lookup("R11 refill", {15'h0abc, 4'd3, 13'h7}, 2'd2, 1, 0, 8'h77, 4'hF);
        check("R11 refill pfn", 64'(rsp_pfn), 64'h5a5a5);
        check("R6 exec grant", 64'(rsp_ex), 64'd1);

        // random fill and traffic
        for (int s = 0; s < 2; s++)
            for (int w = 0; w < 4; w++)
                for (int r = 0; r < 16; r++)
                    do_write(s[0], w[1:0], r[3:0],
                             {vhi($urandom), r[3:0], 5'($urandom), 8'(($urandom % 4) * 8'h11)},
                             $urandom);
        for (int i = 0; i < 500; i++) begin
            if (i % 8 == 7) begin
                int r = $urandom % 16;
                do_write(1'($urandom), 2'($urandom), r[3:0],
                         {vhi($urandom), r[3:0], 5'($urandom), 8'(($urandom % 4) * 8'h11)},
                         $urandom);
            end
            do_lookup("random", {vhi($urandom), 4'($urandom), 13'($urandom)}, 2'($urandom),
                      1'($urandom), ($urandom % 10) == 0, 8'(($urandom % 4) * 8'h11),
                      4'($urandom));
        end
        finish_run();
    end
endmodule